// File: doc/BRIEF.md
# Descriptor Ring Memory-Copy Engine

This block copies data between locations in a shared memory under the control of two paired descriptor rings. The first ring describes where data comes from and the second describes where it goes. Both rings are indexed by one shared consumer index, so slot *n* of the source ring and slot *n* of the destination ring together describe one copy. Each slot is a four-word descriptor. The first word holds a byte address, and the second word holds a 14-bit byte length in bits [29:16] together with flag bits.

Software fills descriptors in memory, then advances the source-ring producer index to hand work over. For each slot the engine fetches both descriptors, moves the data one 32-bit word at a time, and writes a done flag into the destination descriptor. It then advances the consumer index. The destination-ring producer index marks the last slot that software has reclaimed, and the engine never moves onto that slot. A small register port holds the ring setup, the enables with their busy status, and the index-clearing controls. A word-wide memory port with one-cycle read latency carries both descriptor and data traffic.

Top module: `ring_copy_engine`

## Requirements
- R1: After synchronous reset, every register reads zero, the engine is idle, and `mem_req` is low.
- R2: Registers sit at these offsets: source ring base 0x000, count 0x004, producer 0x008, consumer 0x00C; destination ring base 0x100, count 0x104, producer 0x108, consumer 0x10C. A read returns data one cycle after `reg_re`. Writes to the two consumer offsets are ignored.
- R3: A slot starts only when all of these hold: both enables are set, no index-clear bit is held, the consumer index differs from the source producer index, and the consumer index differs from the destination producer index.
- R4: Slot *n* of a ring sits at ring base + 16·n. Its word at +0 is the address, and its word at +4 carries the length in bits [29:16] and the last flag.
- R5: A slot copies ceil(length/4) consecutive words from the source address to the destination address and writes no word beyond them.
- R6: A length above 0x3F80 bytes is treated as 0x3F80.
- R7: A zero-length slot writes no data word, yet still receives its done flag.
- R8: On finishing a slot, the engine rewrites destination word +4 with the done bit set and the last bit copied from the source descriptor. All other bits keep their values. The done bit is at DONE_BIT (default 31) and the last bit is at DONE_BIT-1.
- R9: The shared consumer index advances as (i+1) & (source count − 1) and wraps to zero. Both consumer offsets read this same index.
- R10: Clearing an enable stops new slots. The slot in flight still completes, and busy bits 1 and 3 of the global register stay set until it does.
- R11: Register 0x208 holds index-clear bits at positions 0 and 16. While either bit is set, the consumer index is held at zero and no slot starts.
- R12: The global register at 0x204 has source enable at bit 0, source busy at bit 1, destination enable at bit 2 and destination busy at bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, valid the cycle after `reg_re` |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after a read request |

## Verification
The bench targets these corner cases:
- **Slot under reclaim.** The engine must stop in front of the slot marked by the destination producer index. A design that compared against the wrong index would overwrite a descriptor that software still owns.
- **Oversized length.** A 0x3FFF-byte length must be clamped. An unclamped design would write past the 0x3F80 boundary.
- **Zero-length slot.** A design that still entered the copy loop would corrupt the word after the buffer.
- **Disable mid-copy.** A design that aborted the slot, or dropped busy early, would leave the slot without its done flag or would report idle too soon.
- **Index wrap and index-clear bits.** A wrong mask, or a clear that does not hold the index, would show up as a wrong consumer index at the register port.

// File: rtl/rce_pkg.sv
package rce_pkg;
  localparam int REG_AW = 12;

  localparam logic [REG_AW-1:0] OFS_SRC_BASE = 12'h000;
  localparam logic [REG_AW-1:0] OFS_SRC_CNT  = 12'h004;
  localparam logic [REG_AW-1:0] OFS_SRC_PROD = 12'h008;
  localparam logic [REG_AW-1:0] OFS_SRC_CONS = 12'h00C;
  localparam logic [REG_AW-1:0] OFS_DST_BASE = 12'h100;
  localparam logic [REG_AW-1:0] OFS_DST_CNT  = 12'h104;
  localparam logic [REG_AW-1:0] OFS_DST_PROD = 12'h108;
  localparam logic [REG_AW-1:0] OFS_DST_CONS = 12'h10C;
  localparam logic [REG_AW-1:0] OFS_GLOBAL   = 12'h204;
  localparam logic [REG_AW-1:0] OFS_CLEAR    = 12'h208;

  typedef enum logic [3:0] {
    ST_IDLE, ST_F1, ST_F2, ST_F3, ST_F4, ST_F5,
    ST_CRD, ST_CW1, ST_CW2, ST_WB, ST_ADV
  } eng_state_t;
endpackage

// File: rtl/rce_regs.sv
module rce_regs
  import rce_pkg::*;
#(
  parameter int IDX_W = 16,
  parameter int AW    = 32,
  parameter int DW    = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic [AW-1:0]     src_base,
  output logic [AW-1:0]     dst_base,
  output logic [IDX_W-1:0]  idx_mask,
  output logic [IDX_W-1:0]  src_prod,
  output logic [IDX_W-1:0]  dst_prod,
  output logic              run,
  output logic              hold,
  input  logic [IDX_W-1:0]  slot_idx,
  input  logic              busy
);
  logic [IDX_W:0] src_cnt, dst_cnt;
  logic           en_src, en_dst, clr_src, clr_dst;
  logic [DW-1:0]  rd_mux;

  assign idx_mask = IDX_W'(src_cnt - 1'b1);
  assign run      = en_src & en_dst;
  assign hold     = clr_src | clr_dst;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_base <= '0; dst_base <= '0;
      src_cnt  <= '0; dst_cnt  <= '0;
      src_prod <= '0; dst_prod <= '0;
      en_src   <= 1'b0; en_dst  <= 1'b0;
      clr_src  <= 1'b0; clr_dst <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        OFS_SRC_BASE: src_base <= AW'(reg_wdata);
        OFS_SRC_CNT:  src_cnt  <= reg_wdata[IDX_W:0];
        OFS_SRC_PROD: src_prod <= reg_wdata[IDX_W-1:0];
        OFS_DST_BASE: dst_base <= AW'(reg_wdata);
        OFS_DST_CNT:  dst_cnt  <= reg_wdata[IDX_W:0];
        OFS_DST_PROD: dst_prod <= reg_wdata[IDX_W-1:0];
        OFS_GLOBAL: begin
          en_src <= reg_wdata[0];
          en_dst <= reg_wdata[2];
        end
        OFS_CLEAR: begin
          clr_src <= reg_wdata[0];
          clr_dst <= reg_wdata[16];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      OFS_SRC_BASE: rd_mux = DW'(src_base);
      OFS_SRC_CNT:  rd_mux = DW'(src_cnt);
      OFS_SRC_PROD: rd_mux = DW'(src_prod);
      OFS_SRC_CONS: rd_mux = DW'(slot_idx);
      OFS_DST_BASE: rd_mux = DW'(dst_base);
      OFS_DST_CNT:  rd_mux = DW'(dst_cnt);
      OFS_DST_PROD: rd_mux = DW'(dst_prod);
      OFS_DST_CONS: rd_mux = DW'(slot_idx);
      OFS_GLOBAL:   rd_mux = DW'({busy, en_dst, busy, en_src});
      OFS_CLEAR:    rd_mux = DW'({clr_dst, 15'b0, clr_src});
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         reg_rdata <= '0;
    else if (reg_re) reg_rdata <= rd_mux;
  end
endmodule

// File: rtl/rce_engine.sv
module rce_engine
  import rce_pkg::*;
#(
  parameter int          IDX_W    = 16,
  parameter int          AW       = 32,
  parameter int          DW       = 32,
  parameter int          DONE_BIT = 31,
  parameter logic [13:0] MAX_LEN  = 14'h3F80
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             hold,
  input  logic [AW-1:0]    src_base,
  input  logic [AW-1:0]    dst_base,
  input  logic [IDX_W-1:0] idx_mask,
  input  logic [IDX_W-1:0] src_prod,
  input  logic [IDX_W-1:0] dst_prod,
  output logic [IDX_W-1:0] slot_idx,
  output logic             busy,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata
);
  localparam int LAST_BIT = DONE_BIT - 1;
  localparam int LEN_LO   = 16;
  localparam int LEN_W    = 14;
  localparam int WC_W     = LEN_W - 1;
  localparam int SLOT_SH  = 4;
  localparam int WORD_B   = DW / 8;

  eng_state_t        st;
  logic [IDX_W-1:0]  idx, idx_next;
  logic [AW-1:0]     sa, da, slot_off, src_slot, dst_slot;
  logic [DW-1:0]     dflags, wb_word;
  logic [WC_W-1:0]   wleft, wc_new;
  logic              src_last, can_start;
  logic [LEN_W-1:0]  len_raw, len_cl;
  logic [LEN_W:0]    len_rnd;

  assign slot_off  = AW'(idx) << SLOT_SH;
  assign src_slot  = src_base + slot_off;
  assign dst_slot  = dst_base + slot_off;
  assign len_raw   = mem_rdata[LEN_LO +: LEN_W];
  assign len_cl    = (len_raw > MAX_LEN) ? MAX_LEN : len_raw;
  assign len_rnd   = {1'b0, len_cl} + (LEN_W+1)'(WORD_B - 1);
  assign wc_new    = len_rnd[LEN_W:2];
  assign idx_next  = (idx + 1'b1) & idx_mask;
  assign can_start = run && !hold && (idx != src_prod) && (idx != dst_prod);
  assign slot_idx  = idx;
  assign busy      = (st != ST_IDLE);

  always_comb begin
    wb_word           = dflags;
    wb_word[DONE_BIT] = 1'b1;
    wb_word[LAST_BIT] = src_last;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; idx <= '0;
      sa <= '0; da <= '0; dflags <= '0; wleft <= '0; src_last <= 1'b0;
      mem_req <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
    end else begin
      mem_req <= 1'b0;
      mem_we  <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (hold) idx <= '0;
          else if (can_start) begin
            mem_req <= 1'b1; mem_addr <= src_slot; st <= ST_F1;
          end
        end
        ST_F1: begin
          mem_req <= 1'b1; mem_addr <= src_slot + AW'(WORD_B); st <= ST_F2;
        end
        ST_F2: begin
          mem_req <= 1'b1; mem_addr <= dst_slot; sa <= AW'(mem_rdata);
          st <= ST_F3;
        end
        ST_F3: begin
          mem_req  <= 1'b1; mem_addr <= dst_slot + AW'(WORD_B);
          wleft    <= wc_new; src_last <= mem_rdata[LAST_BIT];
          st       <= ST_F4;
        end
        ST_F4: begin
          da <= AW'(mem_rdata); st <= ST_F5;
        end
        ST_F5: begin
          dflags <= mem_rdata;
          st     <= (wleft == '0) ? ST_WB : ST_CRD;
        end
        ST_CRD: begin
          mem_req <= 1'b1; mem_addr <= sa; st <= ST_CW1;
        end
        ST_CW1: st <= ST_CW2;
        ST_CW2: begin
          mem_req   <= 1'b1; mem_we <= 1'b1;
          mem_addr  <= da;   mem_wdata <= mem_rdata;
          sa        <= sa + AW'(WORD_B);
          da        <= da + AW'(WORD_B);
          wleft     <= wleft - 1'b1;
          st        <= (wleft == WC_W'(1)) ? ST_WB : ST_CRD;
        end
        ST_WB: begin
          mem_req   <= 1'b1; mem_we <= 1'b1;
          mem_addr  <= dst_slot + AW'(WORD_B);
          mem_wdata <= wb_word;
          st        <= ST_ADV;
        end
        ST_ADV: begin
          idx <= idx_next; st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ring_copy_engine.sv
module ring_copy_engine
  import rce_pkg::*;
#(
  parameter int IDX_W    = 16,
  parameter int DONE_BIT = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata
);
  localparam int AW = 32;
  localparam int DW = 32;

  logic [AW-1:0]    src_base, dst_base;
  logic [IDX_W-1:0] idx_mask, src_prod, dst_prod, slot_idx;
  logic             run, hold, busy;

  rce_regs #(.IDX_W(IDX_W), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .src_base(src_base), .dst_base(dst_base), .idx_mask(idx_mask),
    .src_prod(src_prod), .dst_prod(dst_prod), .run(run), .hold(hold),
    .slot_idx(slot_idx), .busy(busy)
  );

  rce_engine #(.IDX_W(IDX_W), .AW(AW), .DW(DW), .DONE_BIT(DONE_BIT)) u_eng (
    .clk(clk), .rst(rst), .run(run), .hold(hold),
    .src_base(src_base), .dst_base(dst_base), .idx_mask(idx_mask),
    .src_prod(src_prod), .dst_prod(dst_prod), .slot_idx(slot_idx),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );
endmodule

// File: rtl/rce_checker.sv
module rce_checker #(
  parameter int IDX_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             hold,
  input logic             busy,
  input logic [IDX_W-1:0] slot_idx,
  input logic [IDX_W-1:0] src_prod,
  input logic [IDX_W-1:0] dst_prod,
  input logic [IDX_W-1:0] idx_mask,
  input logic             mem_req,
  input logic             mem_we
);
  // R1
  write_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_req);

  // R3
  start_allowed_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(run && !hold && slot_idx != src_prod && slot_idx != dst_prod));

  // R9
  idx_advance_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> slot_idx == IDX_W'(($past(slot_idx) + 1'b1) & $past(idx_mask)));

  // R10
  no_start_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !busy) |=> !busy);

  // R11
  clear_holds_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && !busy) |=> slot_idx == '0);
endmodule

bind ring_copy_engine rce_checker #(.IDX_W(IDX_W)) u_rce_chk (
  .clk(clk), .rst(rst), .run(run), .hold(hold), .busy(busy),
  .slot_idx(slot_idx), .src_prod(src_prod), .dst_prod(dst_prod),
  .idx_mask(idx_mask), .mem_req(mem_req), .mem_we(mem_we)
);

// File: tb/ring_copy_engine_bench.sv
module ring_copy_engine_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [31:0] mem [16384];
  int n_run = 0, n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  ring_copy_engine u_ring_copy_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_req) begin
      if (mem_we) mem[mem_addr[15:2]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[15:2]];
    end
  end

  // {last, len}
  localparam logic [14:0] VEC [6] = '{
    {1'b1, 14'd16}, {1'b0, 14'd4}, {1'b1, 14'd2},
    {1'b1, 14'd0},  {1'b0, 14'd40}, {1'b1, 14'd12}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); reg_re = 1'b1; reg_addr = a;
    @(negedge clk); reg_re = 1'b0; d = reg_rdata;
  endtask

  function automatic logic [31:0] pat(int slot, int w);
    return 32'hC0DE_0000 ^ (32'(slot) << 12) ^ 32'(w);
  endfunction

  function automatic int nwords(logic [13:0] len);
    int c = (len > 14'h3F80) ? 32'h3F80 : int'(len);
    return (c + 3) / 4;
  endfunction

  task automatic set_slot(int slot, logic [31:0] sa, logic [31:0] da, logic [13:0] len, logic last);
    int nw = nwords(len);
    mem[(slot*16) >> 2]           = sa;
    mem[(slot*16 + 4) >> 2]       = {1'b0, last, len, 16'h0};
    mem[(32'h100 + slot*16) >> 2] = da;
    mem[(32'h104 + slot*16) >> 2] = 32'h4000_00A5;
    for (int w = 0; w < nw; w++) mem[(sa >> 2) + w] = pat(slot, w);
    for (int w = 0; w <= nw; w++) mem[(da >> 2) + w] = 32'hDEAD_0000 | 32'(w);
  endtask

  task automatic check_slot(string tag, int slot, logic [31:0] da, logic [13:0] len, logic last);
    int nw = nwords(len);
    int bad = 0;
    for (int w = 0; w < nw; w++) if (mem[(da >> 2) + w] !== pat(slot, w)) bad++;
    check({tag, " R5 data words"}, 32'(bad), 32'd0);
    check({tag, " R5 R7 word past end untouched"}, mem[(da >> 2) + nw], 32'hDEAD_0000 | 32'(nw));
    check({tag, " R8 done write-back"}, mem[(32'h104 + slot*16) >> 2],
          32'h8000_00A5 | (32'(last) << 30));
  endtask

  task automatic wait_idx(logic [31:0] target);
    logic [31:0] v;
    for (int k = 0; k < 30000; k++) begin
      reg_rd(12'h00C, v);
      if (v == target) break;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    for (int i = 0; i < 16384; i++) mem[i] = '0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    check("R1 mem_req idle", 32'(mem_req), 32'd0);
    reg_rd(12'h00C, v); check("R1 consumer idx reset", v, 0);
    reg_rd(12'h204, v); check("R1 global reset", v, 0);
    reg_rd(12'h10C, v); check("R1 dst consumer reset", v, 0);

    reg_wr(12'h000, 32'h0000);
    reg_wr(12'h004, 8);
    reg_wr(12'h100, 32'h0100);
    reg_wr(12'h104, 8);
    reg_wr(12'h108, 7);
    reg_wr(12'h204, 5);
    reg_rd(12'h104, v); check("R2 dst count readback", v, 8);

    // table walk: slots 0..5
    for (int i = 0; i < 6; i++)
      set_slot(i, 32'h1000 + 32'(i)*32'h100, 32'h2000 + 32'(i)*32'h100, VEC[i][13:0], VEC[i][14]);
    reg_wr(12'h008, 6);
    wait_idx(6);
    for (int i = 0; i < 6; i++)
      check_slot($sformatf("R4 vec%0d", i), i, 32'h2000 + 32'(i)*32'h100, VEC[i][13:0], VEC[i][14]);
    reg_rd(12'h10C, v); check("R9 shared dst consumer idx", v, 6);
    reg_rd(12'h204, v); check("R12 global idle enabled", v, 5);

    // stall at reclaimed slot, then clamp and wrap
    set_slot(6, 32'h3000, 32'h3800, 14'd8, 1'b0);
    set_slot(7, 32'h4000, 32'h8000, 14'h3FFF, 1'b1);
    reg_wr(12'h008, 0);
    wait_idx(7);
    repeat (60) @(negedge clk);
    reg_rd(12'h00C, v); check("R3 stall at dst producer", v, 7);
    check("R3 stalled slot untouched", mem[(32'h104 + 7*16) >> 2], 32'h4000_00A5);
    check_slot("slot6", 6, 32'h3800, 14'd8, 1'b0);
    reg_wr(12'h108, 5);
    wait_idx(0);
    check_slot("R6 clamp slot7", 7, 32'h8000, 14'h3FFF, 1'b1);
    reg_rd(12'h00C, v); check("R9 wrap to zero", v, 0);

    // disable behaviour
    reg_wr(12'h204, 0);
    set_slot(0, 32'h1000, 32'hC000, 14'd400, 1'b1);
    set_slot(1, 32'h1800, 32'hD000, 14'd4, 1'b0);
    reg_wr(12'h008, 2);
    repeat (50) @(negedge clk);
    reg_rd(12'h00C, v); check("R3 R10 no start when disabled", v, 0);
    reg_wr(12'h204, 5);
    repeat (20) @(negedge clk);
    reg_wr(12'h204, 0);
    reg_rd(12'h204, v); check("R10 R12 busy kept after disable", v, 32'hA);
    repeat (1500) @(negedge clk);
    reg_rd(12'h204, v); check("R10 busy dropped", v, 0);
    reg_rd(12'h00C, v); check("R10 one slot finished", v, 1);
    check_slot("R10 slot0", 0, 32'hC000, 14'd400, 1'b1);
    check("R10 no new slot", mem[(32'h104 + 16) >> 2], 32'h4000_00A5);

    reg_wr(12'h00C, 5);
    reg_rd(12'h00C, v); check("R2 consumer write ignored", v, 1);

    // index clear
    reg_wr(12'h208, 32'h0001_0000);
    repeat (2) @(negedge clk);
    reg_rd(12'h00C, v); check("R11 clear zeroes idx", v, 0);
    reg_rd(12'h10C, v); check("R11 dst idx zero", v, 0);
    reg_wr(12'h204, 5);
    repeat (50) @(negedge clk);
    reg_rd(12'h00C, v); check("R11 held no start", v, 0);
    check("R11 slot1 untouched", mem[(32'h104 + 16) >> 2], 32'h4000_00A5);
    reg_wr(12'h208, 0);
    wait_idx(2);
    check_slot("R8 slot1 last clear", 1, 32'hD000, 14'd4, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule